// File: doc/BRIEF.md
# Prioritised Interrupt Entry and Return Sequencer

This block sits between a set of I/O devices and a processor core. Each device presents four things: a request flag that says it wants service, an enable bit that allows it to interrupt, a 3-bit urgency level and an 8-bit vector. The sequencer picks one winning device. It compares that device's level with the level of the running program. When the core signals that the current instruction has retired, the sequencer takes the interrupt.

Taking an interrupt runs a fixed sequence. The core moves to privileged mode and the program level is raised to the winner's level. If the interrupted code was unprivileged, the active stack pointer is exchanged for the privileged one. Two words go onto a stack that grows downward: first the old status word, then the interrupted PC. A handler address is then fetched from a table at `VEC_BASE + vector` and delivered to the core as a PC load. A return command reverses the sequence. It pops the PC and then the status word, restores the mode, the level and the stack pointer, and reloads the PC. The core's stack traffic uses a simple memory port with one-cycle read latency.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is in unprivileged mode (`user_mode`=1) at level 0, with `sp_out`=`USP_INIT`. `busy`, `irq_pend`, `irq_ack`, `pc_load`, `mem_we` and `mem_re` are all 0.
- R2: A device is a candidate only while its `dev_ie` bit is 1, its `dev_ready` bit is 1 and its level is non-zero. A device that fails any of these never raises `irq_pend` or `irq_ack`.
- R3: Among the candidates, the highest level wins. Between equal levels, the lowest device index wins. In the cycle an interrupt is taken, `irq_ack` is one-hot on the winner (bit i = device i).
- R4: An interrupt is taken only if the winner's level is strictly greater than the current program level. An equal or lower level leaves `irq_pend`=0 and starts nothing.
- R5: An interrupt is taken only in a cycle where `instr_done`=1 and the block is idle. A pending request waits, with `busy`=0, while `instr_done`=0.
- R6: In the cycle after an interrupt is taken, `user_mode`=0 and `cur_prio` equals the winner's level. If the interrupted code was unprivileged, the stack pointer switches to the saved privileged one (initially `SSP_INIT`). Otherwise it is unchanged.
- R7: The two cycles after acceptance write the stack. The first writes the old status word at SP-1; the second writes the interrupted PC (sampled in the accept cycle) at SP-2. The status word holds the unprivileged flag in bit 15 and the level in bits 10:8, with all other bits 0. Writes and reads never occur in the same cycle.
- R8: The third cycle after acceptance reads address `VEC_BASE + vector`. In the fourth, `pc_load`=1 and `pc_val` equals the word read.
- R9: `busy` is 1 from the cycle after acceptance through the `pc_load` cycle, and 0 in the following cycle.
- R10: A return command (`rti_req`) in privileged mode, while idle and with no interrupt being taken, reads the PC at SP and then the status word at SP+1. The next cycle gives `pc_load` with the popped PC. The cycle after that shows the restored mode, level and stack pointer; the unprivileged pointer comes back when the restored mode is unprivileged.
- R11: A return command in unprivileged mode is ignored. No memory access occurs, `busy` stays 0 and the stack pointer is unchanged.
- R12: While a sequence is running, no further request is acknowledged, even one of a higher level with `instr_done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_ready | input | NUM_DEV | Per-device service-wanted flag |
| dev_ie | input | NUM_DEV | Per-device interrupt enable |
| dev_prio | input | NUM_DEV*PRIO_W | Per-device level, device i at bits [i*PRIO_W +: PRIO_W] |
| dev_vec | input | NUM_DEV*VEC_W | Per-device vector, device i at bits [i*VEC_W +: VEC_W] |
| instr_done | input | 1 | Current instruction has retired (boundary) |
| rti_req | input | 1 | Return-from-interrupt command |
| pc_cur | input | DATA_W | PC of the running program |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_re` |
| irq_pend | output | 1 | A candidate outranks the current level |
| irq_ack | output | NUM_DEV | One-hot acceptance pulse |
| busy | output | 1 | Entry or return sequence in progress |
| pc_load | output | 1 | Load `pc_val` into the PC |
| pc_val | output | DATA_W | New PC value |
| user_mode | output | 1 | 1 = unprivileged, 0 = privileged |
| cur_prio | output | PRIO_W | Current program level |
| sp_out | output | DATA_W | Active stack pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | DATA_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The bench keeps four devices, 3-bit levels and the table base at 0x0100. It overrides the stack pointers to 0x8000 (unprivileged) and 0x2000 (privileged), so that the two pointers are easy to tell apart at `sp_out`. With these values the bench can reach a tie between two devices at the same level and a nested interrupt taken at a higher level while already privileged. It can also reach a level equal to the current one being refused and the top vector value 0xFF reading the last table entry. Two returns unwind the nest back to the unprivileged pointer.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_PSR,
        S_PUSH_PC,
        S_VEC_RD,
        S_VEC_LD,
        S_POP_PC,
        S_POP_PSR,
        S_RET_LD
    } seq_state_t;

    localparam int PSR_USER_BIT = 15;
    localparam int PSR_PRIO_LSB = 8;
endpackage

// File: rtl/irq_arb.sv
module irq_arb #(
    parameter int NUM_DEV = 4,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic [NUM_DEV-1:0]        dev_ready,
    input  logic [NUM_DEV-1:0]        dev_ie,
    input  logic [NUM_DEV*PRIO_W-1:0] dev_prio,
    input  logic [NUM_DEV*VEC_W-1:0]  dev_vec,
    output logic                      win_valid,
    output logic [PRIO_W-1:0]         win_prio,
    output logic [IDX_W-1:0]          win_idx,
    output logic [VEC_W-1:0]          win_vec
);
    logic [NUM_DEV-1:0] elig;
    logic [PRIO_W-1:0]  prio_a [NUM_DEV];
    logic [VEC_W-1:0]   vec_a  [NUM_DEV];

    // Unpack each device and qualify it (R2)
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        assign prio_a[g] = dev_prio[g*PRIO_W +: PRIO_W];
        assign vec_a[g]  = dev_vec[g*VEC_W +: VEC_W];
        assign elig[g]   = dev_ie[g] & dev_ready[g] & (|prio_a[g]);
    end

    // Highest level wins; strict compare keeps the lowest index on ties (R3)
    always_comb begin
        win_valid = 1'b0;
        win_prio  = '0;
        win_idx   = '0;
        win_vec   = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (elig[i] && (!win_valid || prio_a[i] > win_prio)) begin
                win_valid = 1'b1;
                win_prio  = prio_a[i];
                win_idx   = IDX_W'(i);
                win_vec   = vec_a[i];
            end
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int NUM_DEV            = 4,
    parameter int PRIO_W             = 3,
    parameter int VEC_W              = 8,
    parameter int DATA_W             = 16,
    parameter logic [DATA_W-1:0] VEC_BASE = 16'h0100,
    parameter logic [DATA_W-1:0] USP_INIT = 16'hFE00,
    parameter logic [DATA_W-1:0] SSP_INIT = 16'h3000,
    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_valid,
    input  logic [PRIO_W-1:0]    win_prio,
    input  logic [IDX_W-1:0]     win_idx,
    input  logic [VEC_W-1:0]     win_vec,
    input  logic                 instr_done,
    input  logic                 rti_req,
    input  logic [DATA_W-1:0]    pc_cur,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 irq_pend,
    output logic [NUM_DEV-1:0]   irq_ack,
    output logic                 busy,
    output logic                 pc_load,
    output logic [DATA_W-1:0]    pc_val,
    output logic                 user_mode,
    output logic [PRIO_W-1:0]    cur_prio,
    output logic [DATA_W-1:0]    sp_out,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [DATA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata
);
    typedef struct packed {
        seq_state_t        st;
        logic              user;
        logic [PRIO_W-1:0] prio;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] oth_sp;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] old_psr;
        logic [VEC_W-1:0]  vec;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      accept;

    function automatic logic [DATA_W-1:0] psr_word(input logic u, input logic [PRIO_W-1:0] p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PSR_USER_BIT] = u;
        w[PSR_PRIO_LSB +: PRIO_W] = p;
        return w;
    endfunction

    always_comb begin
        seq_d     = seq_q;
        accept    = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_load   = 1'b0;
        pc_val    = seq_q.hold;
        unique case (seq_q.st)
            S_IDLE: begin
                if (win_valid && (win_prio > seq_q.prio) && instr_done) begin
                    accept        = 1'b1;
                    seq_d.st      = S_PUSH_PSR;
                    seq_d.old_psr = psr_word(seq_q.user, seq_q.prio);
                    seq_d.hold    = pc_cur;
                    seq_d.vec     = win_vec;
                    seq_d.user    = 1'b0;
                    seq_d.prio    = win_prio;
                    if (seq_q.user) begin
                        seq_d.sp     = seq_q.oth_sp;
                        seq_d.oth_sp = seq_q.sp;
                    end
                end else if (rti_req && !seq_q.user) begin
                    seq_d.st = S_POP_PC;
                end
            end
            S_PUSH_PSR: begin
                mem_we    = 1'b1;
                mem_addr  = seq_q.sp - 1'b1;
                mem_wdata = seq_q.old_psr;
                seq_d.sp  = seq_q.sp - 1'b1;
                seq_d.st  = S_PUSH_PC;
            end
            S_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = seq_q.sp - 1'b1;
                mem_wdata = seq_q.hold;
                seq_d.sp  = seq_q.sp - 1'b1;
                seq_d.st  = S_VEC_RD;
            end
            S_VEC_RD: begin
                mem_re   = 1'b1;
                mem_addr = VEC_BASE + {{(DATA_W-VEC_W){1'b0}}, seq_q.vec};
                seq_d.st = S_VEC_LD;
            end
            S_VEC_LD: begin
                pc_load  = 1'b1;
                pc_val   = mem_rdata;
                seq_d.st = S_IDLE;
            end
            S_POP_PC: begin
                mem_re   = 1'b1;
                mem_addr = seq_q.sp;
                seq_d.sp = seq_q.sp + 1'b1;
                seq_d.st = S_POP_PSR;
            end
            S_POP_PSR: begin
                mem_re     = 1'b1;
                mem_addr   = seq_q.sp;
                seq_d.sp   = seq_q.sp + 1'b1;
                seq_d.hold = mem_rdata;
                seq_d.st   = S_RET_LD;
            end
            S_RET_LD: begin
                pc_load    = 1'b1;
                pc_val     = seq_q.hold;
                seq_d.user = mem_rdata[PSR_USER_BIT];
                seq_d.prio = mem_rdata[PSR_PRIO_LSB +: PRIO_W];
                if (mem_rdata[PSR_USER_BIT]) begin
                    seq_d.sp     = seq_q.oth_sp;
                    seq_d.oth_sp = seq_q.sp;
                end
                seq_d.st = S_IDLE;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st      <= S_IDLE;
            seq_q.user    <= 1'b1;
            seq_q.prio    <= '0;
            seq_q.sp      <= USP_INIT;
            seq_q.oth_sp  <= SSP_INIT;
            seq_q.hold    <= '0;
            seq_q.old_psr <= '0;
            seq_q.vec     <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign irq_pend  = win_valid && (win_prio > seq_q.prio);
    assign irq_ack   = accept ? (NUM_DEV'(1) << win_idx) : '0;
    assign busy      = (seq_q.st != S_IDLE);
    assign user_mode = seq_q.user;
    assign cur_prio  = seq_q.prio;
    assign sp_out    = seq_q.sp;

    AST_WIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_prio != '0)); // R2
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack)); // R3
    AST_LEVEL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_PUSH_PSR) |-> (cur_prio > $past(cur_prio))); // R4
    AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_PUSH_PSR) |-> $past(instr_done)); // R5
    AST_PRIV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && mem_we |-> !user_mode); // R6
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_PUSH_PC) |-> ($past(mem_we) && mem_addr == $past(mem_addr) - 1'b1)); // R7
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R7
    AST_LOAD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (busy && $past(busy))); // R9
    AST_USER_RTI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rti_req && user_mode && irq_ack == '0) |=> (!busy && !mem_re)); // R11
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (irq_ack == '0)); // R12
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int NUM_DEV            = 4,
    parameter int PRIO_W             = 3,
    parameter int VEC_W              = 8,
    parameter int DATA_W             = 16,
    parameter logic [DATA_W-1:0] VEC_BASE = 16'h0100,
    parameter logic [DATA_W-1:0] USP_INIT = 16'hFE00,
    parameter logic [DATA_W-1:0] SSP_INIT = 16'h3000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_DEV-1:0]          dev_ready,
    input  logic [NUM_DEV-1:0]          dev_ie,
    input  logic [NUM_DEV*PRIO_W-1:0]   dev_prio,
    input  logic [NUM_DEV*VEC_W-1:0]    dev_vec,
    input  logic                        instr_done,
    input  logic                        rti_req,
    input  logic [DATA_W-1:0]           pc_cur,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        irq_pend,
    output logic [NUM_DEV-1:0]          irq_ack,
    output logic                        busy,
    output logic                        pc_load,
    output logic [DATA_W-1:0]           pc_val,
    output logic                        user_mode,
    output logic [PRIO_W-1:0]           cur_prio,
    output logic [DATA_W-1:0]           sp_out,
    output logic                        mem_we,
    output logic                        mem_re,
    output logic [DATA_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata
);
    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic              win_valid;
    logic [PRIO_W-1:0] win_prio;
    logic [IDX_W-1:0]  win_idx;
    logic [VEC_W-1:0]  win_vec;

    irq_arb #(
        .NUM_DEV (NUM_DEV),
        .PRIO_W  (PRIO_W),
        .VEC_W   (VEC_W)
    ) u_arb (
        .dev_ready (dev_ready),
        .dev_ie    (dev_ie),
        .dev_prio  (dev_prio),
        .dev_vec   (dev_vec),
        .win_valid (win_valid),
        .win_prio  (win_prio),
        .win_idx   (win_idx),
        .win_vec   (win_vec)
    );

    irq_seq #(
        .NUM_DEV  (NUM_DEV),
        .PRIO_W   (PRIO_W),
        .VEC_W    (VEC_W),
        .DATA_W   (DATA_W),
        .VEC_BASE (VEC_BASE),
        .USP_INIT (USP_INIT),
        .SSP_INIT (SSP_INIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_valid  (win_valid),
        .win_prio   (win_prio),
        .win_idx    (win_idx),
        .win_vec    (win_vec),
        .instr_done (instr_done),
        .rti_req    (rti_req),
        .pc_cur     (pc_cur),
        .mem_rdata  (mem_rdata),
        .irq_pend   (irq_pend),
        .irq_ack    (irq_ack),
        .busy       (busy),
        .pc_load    (pc_load),
        .pc_val     (pc_val),
        .user_mode  (user_mode),
        .cur_prio   (cur_prio),
        .sp_out     (sp_out),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;
    localparam logic [15:0] USP = 16'h8000;
    localparam logic [15:0] SSP = 16'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dev_ready = '0, dev_ie = '0;
    logic [11:0] dev_prio = '0;
    logic [31:0] dev_vec = '0;
    logic        instr_done = 1'b0, rti_req = 1'b0;
    logic [15:0] pc_cur = '0, mem_rdata = '0;
    logic        irq_pend, busy, pc_load, user_mode, mem_we, mem_re;
    logic [3:0]  irq_ack;
    logic [15:0] pc_val, sp_out, mem_addr, mem_wdata;
    logic [2:0]  cur_prio;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [15:0] stk [1024];

    irq_entry_seq #(.NUM_DEV(ND), .USP_INIT(USP), .SSP_INIT(SSP)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .dev_ie(dev_ie),
        .dev_prio(dev_prio), .dev_vec(dev_vec), .instr_done(instr_done),
        .rti_req(rti_req), .pc_cur(pc_cur), .mem_rdata(mem_rdata),
        .irq_pend(irq_pend), .irq_ack(irq_ack), .busy(busy), .pc_load(pc_load),
        .pc_val(pc_val), .user_mode(user_mode), .cur_prio(cur_prio),
        .sp_out(sp_out), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] vt(input logic [7:0] v);
        return 16'hA000 + 16'(v) * 16'd3;
    endfunction

    // Memory model: table computed, stack stored; one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) stk[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) begin
            if (mem_addr >= 16'h0100 && mem_addr <= 16'h01FF) mem_rdata <= vt(mem_addr[7:0]);
            else mem_rdata <= stk[mem_addr[9:0]];
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_dev();
        dev_ready = '0; dev_ie = '0; dev_prio = '0; dev_vec = '0;
    endtask

    task automatic set_dev(input int i, input logic [2:0] p, input logic [7:0] v);
        dev_ready[i] = 1'b1; dev_ie[i] = 1'b1;
        dev_prio[i*3 +: 3] = p; dev_vec[i*8 +: 8] = v;
    endtask

    // Called at negedge+1 with request and instr_done already driven
    task automatic run_entry(input int idx, input logic [2:0] p, input logic [7:0] v,
                             input logic [15:0] pc, input logic [15:0] old_psr, input logic [15:0] sp0);
        chk("R3", "irq_pend", 16'(irq_pend), 16'd1);
        chk("R3", "irq_ack", 16'(irq_ack), 16'(4'b1 << idx));
        @(posedge clk); #1;
        pc_cur = 16'hDEAD;
        clear_dev(); set_dev(3, 3'd7, 8'h77); instr_done = 1'b1;
        @(negedge clk);
        chk("R6", "user_mode", 16'(user_mode), 16'd0);
        chk("R6", "cur_prio", 16'(cur_prio), 16'(p));
        chk("R9", "busy", 16'(busy), 16'd1);
        chk("R7", "push1 we", 16'(mem_we), 16'd1);
        chk("R7", "push1 addr", mem_addr, sp0 - 16'd1);
        chk("R7", "push1 data", mem_wdata, old_psr);
        chk("R12", "ack while busy", 16'(irq_ack), 16'd0);
        @(negedge clk);
        chk("R7", "push2 we", 16'(mem_we), 16'd1);
        chk("R7", "push2 addr", mem_addr, sp0 - 16'd2);
        chk("R7", "push2 data", mem_wdata, pc);
        chk("R12", "ack while busy", 16'(irq_ack), 16'd0);
        @(negedge clk);
        chk("R8", "vec re", 16'(mem_re), 16'd1);
        chk("R8", "vec addr", mem_addr, 16'h0100 + 16'(v));
        @(negedge clk);
        chk("R8", "pc_load", 16'(pc_load), 16'd1);
        chk("R8", "pc_val", pc_val, vt(v));
        chk("R9", "busy at load", 16'(busy), 16'd1);
        chk("R12", "ack while busy", 16'(irq_ack), 16'd0);
        clear_dev(); instr_done = 1'b0;
        @(negedge clk);
        chk("R9", "busy after", 16'(busy), 16'd0);
        chk("R8", "pc_load after", 16'(pc_load), 16'd0);
        chk("R6", "sp after pushes", sp_out, sp0 - 16'd2);
    endtask

    task automatic run_return(input logic [15:0] exp_pc, input logic exp_user, input logic [2:0] exp_prio,
                              input logic [15:0] sp0, input logic [15:0] sp_after);
        @(negedge clk); rti_req = 1'b1;
        @(posedge clk); #1; rti_req = 1'b0;
        @(negedge clk);
        chk("R10", "pop1 re", 16'(mem_re), 16'd1);
        chk("R10", "pop1 addr", mem_addr, sp0);
        @(negedge clk);
        chk("R10", "pop2 re", 16'(mem_re), 16'd1);
        chk("R10", "pop2 addr", mem_addr, sp0 + 16'd1);
        @(negedge clk);
        chk("R10", "ret pc_load", 16'(pc_load), 16'd1);
        chk("R10", "ret pc_val", pc_val, exp_pc);
        @(negedge clk);
        chk("R10", "ret busy", 16'(busy), 16'd0);
        chk("R10", "ret user", 16'(user_mode), 16'(exp_user));
        chk("R10", "ret prio", 16'(cur_prio), 16'(exp_prio));
        chk("R10", "ret sp", sp_out, sp_after);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "user_mode", 16'(user_mode), 16'd1);
        chk("R1", "cur_prio", 16'(cur_prio), 16'd0);
        chk("R1", "sp_out", sp_out, USP);
        chk("R1", "busy", 16'(busy), 16'd0);
        chk("R1", "irq_pend", 16'(irq_pend), 16'd0);
        chk("R1", "strobes", {12'd0, irq_ack | {pc_load, mem_we, mem_re, 1'b0}}, 16'd0);
    endtask

    task automatic t_gating();
        instr_done = 1'b1;
        set_dev(0, 3'd5, 8'h11); dev_ie[0] = 1'b0; #1;
        chk("R2", "ie=0 pend", 16'(irq_pend), 16'd0);
        chk("R2", "ie=0 ack", 16'(irq_ack), 16'd0);
        @(negedge clk); dev_ie[0] = 1'b1; dev_ready[0] = 1'b0; #1;
        chk("R2", "ready=0 pend", 16'(irq_pend), 16'd0);
        @(negedge clk); dev_ready[0] = 1'b1; dev_prio[2:0] = 3'd0; #1;
        chk("R2", "level0 pend", 16'(irq_pend), 16'd0);
        @(negedge clk);
        chk("R2", "no busy", 16'(busy), 16'd0);
        clear_dev(); instr_done = 1'b0;
    endtask

    task automatic t_tie_entry();
        @(negedge clk);
        set_dev(0, 3'd2, 8'h10); set_dev(1, 3'd3, 8'h21); set_dev(2, 3'd3, 8'h22);
        pc_cur = 16'h3456; instr_done = 1'b1; #1;
        run_entry(1, 3'd3, 8'h21, 16'h3456, 16'h8000, SSP);
    endtask

    task automatic t_level_and_boundary();
        @(negedge clk);
        set_dev(0, 3'd3, 8'h30); instr_done = 1'b1; #1;
        chk("R4", "equal level pend", 16'(irq_pend), 16'd0);
        chk("R4", "equal level ack", 16'(irq_ack), 16'd0);
        @(negedge clk);
        chk("R4", "equal level busy", 16'(busy), 16'd0);
        clear_dev(); set_dev(2, 3'd5, 8'h45); instr_done = 1'b0; pc_cur = 16'h5000; #1;
        chk("R5", "pend w/o boundary", 16'(irq_pend), 16'd1);
        chk("R5", "no ack w/o boundary", 16'(irq_ack), 16'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R5", "waits for boundary", 16'(busy), 16'd0);
        instr_done = 1'b1; #1;
        run_entry(2, 3'd5, 8'h45, 16'h5000, 16'h0300, SSP - 16'd2);
    endtask

    task automatic t_returns();
        run_return(16'h5000, 1'b0, 3'd3, SSP - 16'd4, SSP - 16'd2);
        run_return(16'h3456, 1'b1, 3'd0, SSP - 16'd2, USP);
    endtask

    task automatic t_user_rti();
        @(negedge clk); rti_req = 1'b1;
        @(posedge clk); #1; rti_req = 1'b0;
        @(negedge clk);
        chk("R11", "busy", 16'(busy), 16'd0);
        chk("R11", "mem_re", 16'(mem_re), 16'd0);
        chk("R11", "sp", sp_out, USP);
        chk("R11", "user", 16'(user_mode), 16'd1);
    endtask

    task automatic t_top_vector();
        @(negedge clk);
        set_dev(0, 3'd7, 8'hFF); pc_cur = 16'h1234; instr_done = 1'b1; #1;
        run_entry(0, 3'd7, 8'hFF, 16'h1234, 16'h8000, SSP);
        run_return(16'h1234, 1'b1, 3'd0, SSP - 16'd2, USP);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_gating();
        t_tie_entry();
        t_level_and_boundary();
        t_returns();
        t_user_rti();
        t_top_vector();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule